// File: doc/BRIEF.md
# Multicart Bank-Mapping Latch

This block is the bank register of a multi-game cartridge for an 8-bit console. A CPU store anywhere in the upper half of the address space loads it. The value is taken straight from the buses, with no ANDing against ROM data. Some fields come from the low CPU address bits and the rest from the data byte. Together they select a 128 KiB outer bank, a 16 KiB inner bank, and several layout controls:
- a bank-mode bit and a pass-through bit, which between them choose one of four program ROM layouts (two switchable-low-window layouts and two fixed 16 KiB / 32 KiB layouts);
- a nametable arrangement bit;
- a diagnostic flag that holds program ROM A1 high;
- a lock flag that freezes every field except the inner bank.

From the held state and the live CPU address, the block combinationally drives program ROM lines A14 to A19, the program ROM A1 line, and the nametable RAM A10 select. ROM and RAM models, character memory and bus timing are handled elsewhere.

Top module: `mcart_bank_latch`

## Requirements
- R1: A store is taken only when `wrEn` is high and `cpuAddr[15]` is 1. A store with `cpuAddr[15]` = 0 changes no output.
- R2: Field sources on an accepted store:
  - outer bank bit 2 comes from `cpuAddr[2]`;
  - lock comes from `cpuAddr[1]`;
  - diagnostic flag comes from `cpuAddr[0]`;
  - bank mode comes from `cpuData[7]`;
  - pass-through comes from `cpuData[6]`;
  - nametable arrangement comes from `cpuData[5]`;
  - outer bank bits 1..0 come from `cpuData[4:3]`;
  - inner bank comes from `cpuData[2:0]`.
- R3: While lock is 1, an accepted store updates only the inner bank. Every other field keeps its value.
- R4: `prgAddrHi[5:3]` (ROM A19..A17) always equals the outer bank.
- R5: With mode 0 and pass-through 0, `prgAddrHi[2:0]` is the inner bank when `cpuAddr[14]` = 0 and 3'b111 when `cpuAddr[14]` = 1.
- R6: With mode 0 and pass-through 1, `prgAddrHi[2:0]` is the inner bank with bit 0 forced to 0 when `cpuAddr[14]` = 0, and 3'b111 when `cpuAddr[14]` = 1.
- R7: With mode 1 and pass-through 0, `prgAddrHi[2:0]` is the inner bank unchanged in both windows.
- R8: With mode 1 and pass-through 1, `prgAddrHi[2:1]` is inner bank bits 2..1 and `prgAddrHi[0]` follows `cpuAddr[14]`.
- R9: `ciramA10` follows `ppuA11` when the arrangement bit is 0 (horizontal) and `ppuA10` when it is 1 (vertical).
- R10: `prgA1` is 1 while the diagnostic flag is 1. Otherwise it equals `cpuAddr[1]`.
- R11: A synchronous `rst` clears every field, including lock. After reset the block is in the mode-0 / pass-through-0 layout with outer and inner bank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Store strobe, sampled on the rising clock edge |
| cpuAddr | input | 16 | CPU address bus |
| cpuData | input | 8 | CPU data bus |
| ppuA10 | input | 1 | Video address line 10 |
| ppuA11 | input | 1 | Video address line 11 |
| prgAddrHi | output | 6 | Program ROM A19..A14 |
| prgA1 | output | 1 | Program ROM A1 |
| ciramA10 | output | 1 | Nametable RAM A10 select |

## Verification
The assertions check on every cycle that locked stores never reach the control fields and that stores below the upper half are never taken. They also check that the inner bank captures the data bits on each accepted store, that the fixed high window and the forced-even low window hold in the two switchable layouts, and that the diagnostic flag holds A1 high. Only the bench scenarios can show the complete field layout and the exact output for every combination of mode, outer bank and inner bank in both windows. The same applies to the nametable arrangement, to recovery from lock through reset, and to the reset state itself.

// File: rtl/mcart_pkg.sv
package mcart_pkg;
  parameter int OUTER_W = 3;
  parameter int INNER_W = 3;

  typedef struct packed {
    logic loadInner;
    logic loadCtrl;
  } strobe_t;

  typedef struct packed {
    logic               lockFlag;
    logic               diagFlag;
    logic               bankMode;
    logic               passThru;
    logic               ntVert;
    logic [OUTER_W-1:0] outerBank;
  } ctrl_t;
endpackage

// File: rtl/mcart_latch_ctrl.sv
module mcart_latch_ctrl
  import mcart_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wrEn,
  input  logic    addrTop,
  input  logic    lockQ,
  output strobe_t strb
);
  logic accept;

  assign accept         = wrEn & addrTop;
  assign strb.loadInner = accept;
  assign strb.loadCtrl  = accept & ~lockQ;

  // R1: a store aimed below the upper half is never taken
  assert_low_half_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    !addrTop |-> !strb.loadInner && !strb.loadCtrl);
endmodule

// File: rtl/mcart_latch_dp.sv
module mcart_latch_dp
  import mcart_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strb,
  input  logic [ADDR_W-1:0]          cpuAddr,
  input  logic [DATA_W-1:0]          cpuData,
  input  logic                       ppuA10,
  input  logic                       ppuA11,
  output logic                       lockQ,
  output logic [OUTER_W+INNER_W-1:0] prgAddrHi,
  output logic                       prgA1,
  output logic                       ciramA10
);
  localparam int HI_W = OUTER_W + INNER_W;
  localparam logic [INNER_W-1:0] TOP_BANK = '1;

  ctrl_t              ctrlQ, ctrlD;
  logic [INNER_W-1:0] innerQ;
  logic [INNER_W-1:0] innerEff;
  logic               winHigh;

  always_comb begin
    ctrlD                = ctrlQ;
    ctrlD.outerBank      = {cpuAddr[2], cpuData[4:3]};
    ctrlD.lockFlag       = cpuAddr[1];
    ctrlD.diagFlag       = cpuAddr[0];
    ctrlD.bankMode       = cpuData[7];
    ctrlD.passThru       = cpuData[6];
    ctrlD.ntVert         = cpuData[5];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ  <= '0;
      innerQ <= '0;
    end else begin
      if (strb.loadCtrl)  ctrlQ  <= ctrlD;
      if (strb.loadInner) innerQ <= cpuData[INNER_W-1:0];
    end
  end

  assign winHigh = cpuAddr[14];

  always_comb begin
    unique case ({ctrlQ.bankMode, ctrlQ.passThru})
      2'b00:   innerEff = winHigh ? TOP_BANK : innerQ;
      2'b01:   innerEff = winHigh ? TOP_BANK : {innerQ[INNER_W-1:1], 1'b0};
      2'b10:   innerEff = innerQ;
      default: innerEff = {innerQ[INNER_W-1:1], winHigh};
    endcase
  end

  assign prgAddrHi = {ctrlQ.outerBank, innerEff};
  assign prgA1     = cpuAddr[1] | ctrlQ.diagFlag;
  assign ciramA10  = ctrlQ.ntVert ? ppuA10 : ppuA11;
  assign lockQ     = ctrlQ.lockFlag;

  // R3: a locked register never receives a control load
  assert_locked_no_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
    lockQ |-> !strb.loadCtrl);
  // R3: control fields hold across a store made while locked
  assert_locked_fields_stable_R3: assert property (@(posedge clk) disable iff (rst)
    lockQ && strb.loadInner |=> $stable(ctrlQ));
  // R2: inner bank captures the low data bits on every accepted store
  assert_inner_capture_R2: assert property (@(posedge clk) disable iff (rst)
    strb.loadInner |=> innerQ == $past(cpuData[INNER_W-1:0]));
  // R5: fixed high window in the switchable layouts
  assert_high_window_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrlQ.bankMode && winHigh |-> prgAddrHi[INNER_W-1:0] == TOP_BANK);
  // R6: defective layout never selects an odd bank in the low window
  assert_defect_even_R6: assert property (@(posedge clk) disable iff (rst)
    !ctrlQ.bankMode && ctrlQ.passThru && !winHigh |-> !prgAddrHi[0]);
  // R10: diagnostic flag holds A1 high
  assert_diag_a1_R10: assert property (@(posedge clk) disable iff (rst)
    ctrlQ.diagFlag |-> prgA1);

  logic unusedBits;
  assign unusedBits = ^{cpuAddr[ADDR_W-1:15], cpuAddr[13:3], cpuData[DATA_W-1:5], HI_W[0]};
endmodule

// File: rtl/mcart_bank_latch.sv
module mcart_bank_latch
  import mcart_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuData,
  input  logic        ppuA10,
  input  logic        ppuA11,
  output logic [5:0]  prgAddrHi,
  output logic        prgA1,
  output logic        ciramA10
);
  strobe_t strb;
  logic    lockQ;

  mcart_latch_ctrl i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .addrTop (cpuAddr[15]),
    .lockQ   (lockQ),
    .strb    (strb)
  );

  mcart_latch_dp #(.ADDR_W(16), .DATA_W(8)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cpuAddr   (cpuAddr),
    .cpuData   (cpuData),
    .ppuA10    (ppuA10),
    .ppuA11    (ppuA11),
    .lockQ     (lockQ),
    .prgAddrHi (prgAddrHi),
    .prgA1     (prgA1),
    .ciramA10  (ciramA10)
  );
endmodule

// File: tb/test_mcart_bank_latch.sv
module test_mcart_bank_latch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [15:0] cpuAddr = 16'h8000;
  logic [7:0]  cpuData = 8'h00;
  logic        ppuA10 = 1'b0;
  logic        ppuA11 = 1'b0;
  logic [5:0]  prgAddrHi;
  logic        prgA1;
  logic        ciramA10;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // shadow model of the register, built from the requirements
  logic [2:0] mOuter, mInner;
  logic       mLock, mDiag, mMode, mPass, mVert;

  always #5 clk = ~clk;

  mcart_bank_latch i_mcart_bank_latch (
    .clk(clk), .rst(rst), .wrEn(wrEn), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .ppuA10(ppuA10), .ppuA11(ppuA11),
    .prgAddrHi(prgAddrHi), .prgA1(prgA1), .ciramA10(ciramA10)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] expHi(input logic a14);
    logic [2:0] lo;
    case ({mMode, mPass})
      2'b00:   lo = a14 ? 3'b111 : mInner;
      2'b01:   lo = a14 ? 3'b111 : {mInner[2:1], 1'b0};
      2'b10:   lo = mInner;
      default: lo = {mInner[2:1], a14};
    endcase
    return {mOuter, lo};
  endfunction

  task automatic modelReset();
    mOuter = 0; mInner = 0; mLock = 0; mDiag = 0; mMode = 0; mPass = 0; mVert = 0;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (a[15]) begin
      mInner = d[2:0];
      if (!mLock) begin
        mOuter = {a[2], d[4:3]};
        mLock = a[1]; mDiag = a[0];
        mMode = d[7]; mPass = d[6]; mVert = d[5];
      end
    end
  endtask

  function automatic string layoutReq();
    case ({mMode, mPass})
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R7";
      default: return "R8";
    endcase
  endfunction

  // checks both windows, A1 behaviour and nametable select
  task automatic checkAll(input string tag);
    for (int w = 0; w < 2; w++) begin
      @(negedge clk);
      cpuAddr = 16'h8000 | (w[0] ? 16'h4000 : 16'h0000);
      #1;
      chk({tag, " ", layoutReq()}, prgAddrHi[2:0], expHi(w[0]) & 6'h07);
      chk({tag, " R4"}, prgAddrHi[5:3], mOuter);
    end
    for (int p = 0; p < 4; p++) begin
      cpuAddr = 16'h8000 | (p[0] ? 16'h0002 : 16'h0000);
      ppuA10 = p[0]; ppuA11 = p[1];
      #1;
      chk({tag, " R9"}, ciramA10, mVert ? p[0] : p[1]);
      chk({tag, " R10"}, prgA1, mDiag | p[0]);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    checkAll("reset R11");

    // R2 R4-R9: sweep layouts, outer and inner banks
    for (int mt = 0; mt < 4; mt++)
      for (int ob = 0; ob < 8; ob++)
        for (int ib = 0; ib < 8; ib++) begin
          doWrite(16'h8000 | {13'd0, ob[2], 2'b00},
                  {mt[1], mt[0], ib[0] ^ ob[0], ob[1:0], ib[2:0]});
          checkAll("sweep R2");
        end

    // R1: stores below the upper half are ignored
    doWrite(16'h8004, 8'b1011_1101);
    doWrite(16'h7FFF, 8'b0100_0010);
    checkAll("low-half R1");
    @(negedge clk);
    rst = 1'b0;

    // R10: diagnostic flag via address bit 0
    doWrite(16'hC001, 8'b0000_0110);
    checkAll("diag R10");

    // R3: lock freezes everything except the inner bank
    doWrite(16'h8006, 8'b1101_0011);
    checkAll("lock-set R3");
    doWrite(16'hFFF1, 8'b0010_1100);
    checkAll("locked R3");
    doWrite(16'h8000, 8'b0100_0111);
    checkAll("locked2 R3");

    // R11: reset clears lock, writes take effect again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    modelReset();
    checkAll("post-reset R11");
    doWrite(16'h8004, 8'b1011_1010);
    checkAll("unlocked R11");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule